// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse-Width Modulator

This block drives four pulse outputs. Each output is a periodic waveform, and software configures it through a small word-addressed register bus. Every channel has three registers. The control register holds an enable and a 14-bit clock divider. The second register holds the high-time count and the third holds the period count. A single chip-wide enable register gates all four channels together.

The divider sets the rate of a channel tick. On every tick the 16-bit position counter advances. The output is high while the position is below the high-time count, and it wraps after the period count. Values written while a channel runs are staged. They take effect only at the next wrap, so a pulse is never cut short or stretched by a write.

Software changes one field by reading a register, modifying it and writing it back. This works because every implemented field reads back exactly as written. A write lands one clock after it is presented. Reads are combinational from the current address.

Top module: `pwm4_periph`

## Requirements
- R1: After reset, every output is low and every register reads zero.
- R2: Register map. Channel n uses byte address n*0x10 plus an offset: control at 0x0, high-time at 0x4, period at 0x8. The chip-wide enable is bit 0 at address 0x3C. Control bit 0 is the channel enable and bits [15:2] are the divider P. High-time (DC) and period (PV) are 16-bit values in bits [15:0]. Each implemented field reads back the value last written to it.
- R3: Writes to unmapped addresses are ignored. Unmapped addresses read zero. Unimplemented bits of mapped registers also read zero.
- R4: A channel output is low whenever the channel enable or the chip-wide enable is clear.
- R5: A running channel repeats with a period of (P+1)*PV clocks.
- R6: The output stays high for the first (P+1)*DC clocks of each period. It first rises one clock after the edge at which both enables are seen set.
- R7: If DC is greater than or equal to PV (PV nonzero), the output stays high for the whole time the channel runs.
- R8: If DC or PV is zero, the output stays low. A zero PV is counted as a period of P+1 clocks, so a new staged value is picked up after that time.
- R9: Divider, high-time and period values written while a channel runs take effect only at the next period boundary.
- R10: Clearing either enable stops the channel and resets its position. Enabling it again starts a fresh period with the output high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pwm_out | output | 4 | Pulse outputs, one bit per channel |

## Verification
The assertions check these behaviours on every cycle:
- Unmapped addresses return zero.
- No output is high in the cycle after the chip-wide enable or a channel enable is seen clear.
- An output goes high one clock after its channel starts, when its staged counts are nonzero.

Some properties depend on exact period and high-time lengths, deferred updates at the wrap point, and the saturated and zero-count cases. Only the bench's scenarios show these. It checks them against a reference model that tracks elapsed clocks within each period and compares the model with the outputs and the read data every clock.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;
  // byte offsets inside one channel bank (16-byte stride)
  localparam logic [3:0] OFS_CTRL = 4'h0;
  localparam logic [3:0] OFS_DUTY = 4'h4;
  localparam logic [3:0] OFS_PER  = 4'h8;
  // chip-wide enable register
  localparam logic [7:0] ADDR_GLB = 8'h3C;
endpackage

// File: rtl/pwm4_regs.sv
module pwm4_regs
  import pwm4_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int PRE_W  = 14,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wdata,
  input  logic                         we,
  output logic [DATA_W-1:0]            rdata,
  output logic [NCH-1:0]               ch_en,
  output logic [NCH-1:0][PRE_W-1:0]    ch_pre,
  output logic [NCH-1:0][CNT_W-1:0]    ch_duty,
  output logic [NCH-1:0][CNT_W-1:0]    ch_per,
  output logic                         glb_en
);
  localparam int CH_W = ADDR_W - 4;

  logic [NCH-1:0]            en_q, en_d;
  logic [NCH-1:0][PRE_W-1:0] pre_q, pre_d;
  logic [NCH-1:0][CNT_W-1:0] dc_q, dc_d, pv_q, pv_d;
  logic                      glb_q, glb_d;

  // write decode: next-state
  always_comb begin
    en_d  = en_q;
    pre_d = pre_q;
    dc_d  = dc_q;
    pv_d  = pv_q;
    glb_d = glb_q;
    if (addr == ADDR_W'(ADDR_GLB)) glb_d = wdata[0];
    for (int i = 0; i < NCH; i++) begin
      if (addr[ADDR_W-1:4] == CH_W'(i)) begin
        case (addr[3:0])
          OFS_CTRL: begin
            en_d[i]  = wdata[0];
            pre_d[i] = wdata[PRE_W+1:2];
          end
          OFS_DUTY: dc_d[i] = wdata[CNT_W-1:0];
          OFS_PER:  pv_d[i] = wdata[CNT_W-1:0];
          default: ;
        endcase
      end
    end
  end

  // register process with write strobe as clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      pre_q <= '0;
      dc_q  <= '0;
      pv_q  <= '0;
      glb_q <= 1'b0;
    end else if (we) begin
      en_q  <= en_d;
      pre_q <= pre_d;
      dc_q  <= dc_d;
      pv_q  <= pv_d;
      glb_q <= glb_d;
    end
  end

  // readback mux
  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(ADDR_GLB)) rdata[0] = glb_q;
    for (int i = 0; i < NCH; i++) begin
      if (addr[ADDR_W-1:4] == CH_W'(i)) begin
        case (addr[3:0])
          OFS_CTRL: begin
            rdata[0]         = en_q[i];
            rdata[PRE_W+1:2] = pre_q[i];
          end
          OFS_DUTY: rdata[CNT_W-1:0] = dc_q[i];
          OFS_PER:  rdata[CNT_W-1:0] = pv_q[i];
          default: ;
        endcase
      end
    end
  end

  assign ch_en   = en_q;
  assign ch_pre  = pre_q;
  assign ch_duty = dc_q;
  assign ch_per  = pv_q;
  assign glb_en  = glb_q;
endmodule

// File: rtl/pwm4_chan.sv
module pwm4_chan #(
  parameter int PRE_W = 14,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] cfg_pre,
  input  logic [CNT_W-1:0] cfg_dc,
  input  logic [CNT_W-1:0] cfg_pv,
  output logic             pwm
);
  logic             act_q, act_d;
  logic [PRE_W-1:0] pc_q, pc_d, sp_q, sp_d;
  logic [CNT_W-1:0] cc_q, cc_d, sdc_q, sdc_d, spv_q, spv_d;
  logic             tick, last, load;

  always_comb begin
    tick  = (pc_q == sp_q);
    last  = (spv_q == '0) || (cc_q == spv_q - 1'b1);
    act_d = run;
    pc_d  = pc_q;
    cc_d  = cc_q;
    load  = 1'b0;
    if (!run || !act_q) begin
      pc_d = '0;
      cc_d = '0;
      load = 1'b1;
    end else if (tick) begin
      pc_d = '0;
      if (last) begin
        cc_d = '0;
        load = 1'b1;
      end else begin
        cc_d = cc_q + 1'b1;
      end
    end else begin
      pc_d = pc_q + 1'b1;
    end
    sp_d  = load ? cfg_pre : sp_q;
    sdc_d = load ? cfg_dc  : sdc_q;
    spv_d = load ? cfg_pv  : spv_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      pc_q  <= '0;
      cc_q  <= '0;
      sp_q  <= '0;
      sdc_q <= '0;
      spv_q <= '0;
    end else begin
      act_q <= act_d;
      pc_q  <= pc_d;
      cc_q  <= cc_d;
      sp_q  <= sp_d;
      sdc_q <= sdc_d;
      spv_q <= spv_d;
    end
  end

  assign pwm = act_q && (spv_q != '0) && (sdc_q != '0) && (cc_q < sdc_q);
endmodule

// File: rtl/pwm4_periph.sv
module pwm4_periph #(
  parameter int NCH    = 4,
  parameter int PRE_W  = 14,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    pwm_out
);
  logic [1:0]                rst_sync;
  logic                      rst_int_n;
  logic [NCH-1:0]            ch_en;
  logic [NCH-1:0][PRE_W-1:0] ch_pre;
  logic [NCH-1:0][CNT_W-1:0] ch_duty, ch_per;
  logic                      glb_en;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  pwm4_regs #(
    .NCH(NCH), .PRE_W(PRE_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_int_n), .addr(bus_addr), .wdata(bus_wdata),
    .we(bus_we), .rdata(bus_rdata), .ch_en(ch_en), .ch_pre(ch_pre),
    .ch_duty(ch_duty), .ch_per(ch_per), .glb_en(glb_en)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwm4_chan #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst_n(rst_int_n), .run(ch_en[g] & glb_en),
      .cfg_pre(ch_pre[g]), .cfg_dc(ch_duty[g]), .cfg_pv(ch_per[g]),
      .pwm(pwm_out[g])
    );
  end
endmodule

// File: rtl/pwm4_chk.sv
module pwm4_chk #(
  parameter int NCH    = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic [DATA_W-1:0]         bus_rdata,
  input logic [NCH-1:0]            pwm_out,
  input logic [NCH-1:0]            ch_en,
  input logic                      glb_en,
  input logic [NCH-1:0][CNT_W-1:0] ch_duty,
  input logic [NCH-1:0][CNT_W-1:0] ch_per
);
  function automatic logic is_mapped(input logic [ADDR_W-1:0] a);
    if (a == ADDR_W'(8'h3C)) return 1'b1;
    return (int'(a[ADDR_W-1:4]) < NCH) &&
           (a[3:0] == 4'h0 || a[3:0] == 4'h4 || a[3:0] == 4'h8);
  endfunction

  // R3
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_mapped(bus_addr) |-> (bus_rdata == '0));

  // R4
  glb_off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |=> (pwm_out == '0));

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // R4
    ch_off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_en[g] |=> !pwm_out[g]);

    // R10
    start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ch_en[g] & glb_en) && ch_duty[g] != '0 && ch_per[g] != '0)
        |=> pwm_out[g]);
  end
endmodule

bind pwm4_periph pwm4_chk #(
  .NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .pwm_out(pwm_out), .ch_en(ch_en), .glb_en(glb_en),
  .ch_duty(ch_duty), .ch_per(ch_per)
);

// File: tb/sim_pwm4_periph.sv
module sim_pwm4_periph;
  logic        clk;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_we;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out;

  int nvec, nfail;
  bit done;

  // bench mirror of the register map and reference model state
  int m_en[4], m_pre[4], m_dc[4], m_pv[4], m_glb;
  int s_pre[4], s_dc[4], s_pv[4], t[4], act[4];

  pwm4_periph u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int exp_rd(input int a);
    int c;
    if (a == 'h3C) return m_glb;
    c = a / 16;
    if (c >= 4) return 0;
    case (a % 16)
      0: return m_en[c] + m_pre[c] * 4;
      4: return m_dc[c];
      8: return m_pv[c];
      default: return 0;
    endcase
  endfunction

  function automatic logic [3:0] exp_out();
    logic [3:0] o;
    for (int c = 0; c < 4; c++)
      o[c] = (act[c] != 0) && s_pv[c] != 0 && s_dc[c] != 0 &&
             t[c] < (s_pre[c] + 1) * s_dc[c];
    return o;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 4; c++) begin
        m_en[c] = 0; m_pre[c] = 0; m_dc[c] = 0; m_pv[c] = 0;
        s_pre[c] = 0; s_dc[c] = 0; s_pv[c] = 0; t[c] = 0; act[c] = 0;
      end
      m_glb = 0;
    end else begin
      for (int c = 0; c < 4; c++) begin
        int len;
        bit ld;
        ld = 0;
        if (!(m_en[c] != 0 && m_glb != 0)) begin
          act[c] = 0; t[c] = 0; ld = 1;
        end else if (act[c] == 0) begin
          act[c] = 1; t[c] = 0; ld = 1;
        end else begin
          len = (s_pre[c] + 1) * (s_pv[c] == 0 ? 1 : s_pv[c]);
          if (t[c] == len - 1) begin t[c] = 0; ld = 1; end
          else t[c] = t[c] + 1;
        end
        if (ld) begin s_pre[c] = m_pre[c]; s_dc[c] = m_dc[c]; s_pv[c] = m_pv[c]; end
      end
      if (bus_we) begin
        int a, c;
        a = int'(bus_addr);
        c = a / 16;
        if (a == 'h3C) m_glb = int'(bus_wdata[0]);
        else if (c < 4) begin
          case (a % 16)
            0: begin m_en[c] = int'(bus_wdata[0]); m_pre[c] = int'(bus_wdata[15:2]); end
            4: m_dc[c] = int'(bus_wdata[15:0]);
            8: m_pv[c] = int'(bus_wdata[15:0]);
            default: ;
          endcase
        end
      end
    end
    #5;
    if (!done) begin
      // R4 R5 R6 R7 R8 R9 R10: output waveform per clock
      nvec++;
      if (pwm_out !== exp_out()) begin
        nfail++;
        $display("FAIL R4 R5 R6 R7 R8 R9 R10 pwm_out at %0t: actual %b expected %b",
                 $time, pwm_out, exp_out());
      end
      // R1 R2 R3: readback per clock
      nvec++;
      if (bus_rdata !== 32'(exp_rd(int'(bus_addr)))) begin
        nfail++;
        $display("FAIL R1 R2 R3 rdata addr %h: actual %h expected %h",
                 bus_addr, bus_rdata, exp_rd(int'(bus_addr)));
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_addr = 8'(a); bus_wdata = 32'(d); bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sweep();
    for (int a = 0; a < 'h48; a++) begin
      @(negedge clk);
      bus_addr = 8'(a);
    end
  endtask

  initial begin
    nvec = 0; nfail = 0; done = 0;
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(5);
    // R1: reset values read zero
    sweep();
    // R2 R3: readback of all fields, unused bits and unmapped offsets
    wr('h00, 'hFFFF_FFFE); wr('h14, 'h1234_ABCD); wr('h28, 'hFFFF_5A5A);
    wr('h0C, 'hFFFF_FFFF); wr('h1C, 'hFFFF_FFFF); wr('h44, 'hFFFF_FFFF);
    wr('h3D, 'hFFFF_FFFF); wr('h3C, 'hFFFF_FFFE);
    sweep();
    wr('h00, 0); wr('h14, 0); wr('h28, 0);
    // R4: channels enabled but chip-wide enable clear -> low
    wr('h04, 3); wr('h08, 8); wr('h00, 1);
    wr('h14, 2); wr('h18, 5); wr('h10, 2*4 + 1);
    wr('h24, 10); wr('h28, 4); wr('h20, 1);        // R7
    wr('h34, 0); wr('h38, 6); wr('h30, 1);         // R8 duty zero
    idle(20);
    // R5 R6: start all channels
    wr('h3C, 1);
    idle(120);
    // R9: change duty and divider mid-period
    wr('h04, 6); idle(3); wr('h00, 1*4 + 1); wr('h08, 9);
    idle(120);
    // R10: stop and restart a channel mid-period
    wr('h10, 2*4); idle(7); wr('h10, 2*4 + 1);
    idle(60);
    // R4 R10: chip-wide disable then enable
    wr('h3C, 0); idle(10); wr('h3C, 1);
    idle(60);
    // R8: zero period, then recovery at a boundary
    wr('h34, 2); wr('h38, 0); idle(20); wr('h38, 3);
    idle(40);
    // R7: duty equals period
    wr('h24, 4); idle(40);
    // R5 R6: large divider
    wr('h14, 1); wr('h18, 3); wr('h10, 100*4 + 1);
    idle(800);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule